// File: doc/BRIEF.md
# Debug Test Access Port with Instruction-Transfer Chain

This block is the debugger-facing test access port of a processor core. A four-wire serial interface (clock, mode select, data in, data out) plus a synchronous reset drives a sixteen-state TAP controller. A 4-bit instruction register chooses the debug operation. A 5-bit chain-select register, loaded in two steps, picks which internal scan chain the data path reaches.

Two chains reach the core. The instruction-transfer chain carries a 32-bit core instruction in and a read-only completion flag out. The debugger shifts an instruction in, and at the update step the port hands it to a halted core with a one-cycle strobe. The flag then reads zero until the core reports the instruction done. The debug status/control chain holds the halting-debug enable, which only the port can write, and a sticky record that the core saw an imprecise data abort. A dedicated restart instruction makes the port send the core a one-cycle release request when the controller enters Run-Test/Idle.

All state moves on the rising edge of `tck`. `tdo` is a multiplexer of register bits, so it holds the bit that the next rising edge shifts out.

Top module: `dbg_tap`

## Requirements
- R1: While `rst` is high at a rising edge of `tck`, the port goes to Test-Logic-Reset with instruction 0xF, chain 0 selected, completion flag 1, halt enable 0, and `instr_valid`, `instr_word`, `restart_req` all 0.
- R2: Five rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the instruction register then holds 0xF (bypass) without `rst`.
- R3: The instruction register is 4 bits, shifted least significant bit first, and captures 4'b0001. Opcodes: 0x0 write-side chain access, 0x2 chain select, 0x4 restart, 0xC read-side chain access, 0xD direct instruction-chain select, 0xF bypass. Restart, bypass and every other code select a 1-bit bypass register that captures 0.
- R4: Under opcode 0x2 the data path is a 5-bit chain-number register, least significant bit first. It captures the current chain number, and the chain select takes the shifted value at Update-DR.
- R5: The instruction chain is 33 bits, shifted least significant bit first. Bit 0 is the completion flag and bits 32:1 are the instruction. At capture, bits 32:1 load the last issued instruction. Opcode 0xD selects it, and so do 0x0 and 0xC when chain 4 is selected.
- R6: At Update-DR of the instruction chain under opcode 0xD, or under 0x0 with chain 4 selected, with `core_halted` high, `instr_valid` is high for exactly the next cycle and `instr_word` takes bits 32:1. Under 0xC, or with `core_halted` low, no strobe is issued.
- R7: The completion flag is captured into bit 0 at Capture-DR. An issue clears it; otherwise a high `instr_done` sets it. When both happen at the same edge, the issue wins.
- R8: The value shifted into bit 0 of the instruction chain reaches neither the completion flag nor the issued instruction.
- R9: When an edge moves the controller into Run-Test/Idle from another state and the instruction register after that edge holds 0x4, `restart_req` is high for exactly the following cycle. Staying in Run-Test/Idle, or entering it under another opcode, gives no pulse.
- R10: Chain 1 is a 32-bit status/control register, shifted least significant bit first. Bit 0 reads `core_halted`, bit 14 is the halt enable (output `halt_en`), and bit 19 is set by `core_abort` and stays set until reset. All other bits read 0. Bit 14 is written at Update-DR only under opcode 0x0. Opcode 0xC only reads, and no debugger write changes bit 19.
- R11: `tdo` is bit 0 of the instruction shift register in Shift-IR, bit 0 of the selected data register in Shift-DR, and 0 in every other state. Chains other than 1 and 4 act as the bypass register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the whole port |
| tms | input | 1 | Mode select that steers the TAP controller |
| tdi | input | 1 | Serial data into the selected shift register |
| tdo | output | 1 | Serial data out of the selected shift register |
| core_halted | input | 1 | Core is stopped in debug state |
| instr_done | input | 1 | Core finished the last issued instruction |
| core_abort | input | 1 | Core recognised an imprecise data abort |
| instr_valid | output | 1 | One-cycle strobe: issue `instr_word` to the core |
| instr_word | output | 32 | Instruction handed to the core |
| restart_req | output | 1 | One-cycle request for the core to leave debug state |
| halt_en | output | 1 | Halting-debug enable bit of the status/control register |

## Verification
The bench loads a completion event into the very cycle of an issue. A design that lets the done input win would then read the flag back as 1 instead of 0. It shifts a 1 into the read-only flag position and captures again; a design that keeps the shifted bit would show a stale 1 or issue a corrupted word. It tries to issue with the core running, under the read-side opcode and through the direct-select opcode with a different chain selected, where a wrong gate either strobes when it must not or stays silent. It enters Run-Test/Idle under restart from Update-IR and from Update-DR, and under other opcodes. A decoder that checks the old instruction register misses the first entry, and one without edge detection pulses on every idle cycle.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_CHSEL, DR_ITX, DR_CTRL} dr_sel_e;

  localparam logic [IR_W-1:0] OP_WRITE   = 4'h0;
  localparam logic [IR_W-1:0] OP_CHSEL   = 4'h2;
  localparam logic [IR_W-1:0] OP_RESTART = 4'h4;
  localparam logic [IR_W-1:0] OP_READ    = 4'hC;
  localparam logic [IR_W-1:0] OP_ITXDIR  = 4'hD;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      TS_RESET:    tap_next = m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     tap_next = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   tap_next = m ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   tap_next = m ? TS_EX1_DR   : TS_SHIFT_DR;
      TS_SHIFT_DR: tap_next = m ? TS_EX1_DR   : TS_SHIFT_DR;
      TS_EX1_DR:   tap_next = m ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: tap_next = m ? TS_EX2_DR   : TS_PAUSE_DR;
      TS_EX2_DR:   tap_next = m ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   tap_next = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   tap_next = m ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   tap_next = m ? TS_EX1_IR   : TS_SHIFT_IR;
      TS_SHIFT_IR: tap_next = m ? TS_EX1_IR   : TS_SHIFT_IR;
      TS_EX1_IR:   tap_next = m ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: tap_next = m ? TS_EX2_IR   : TS_PAUSE_IR;
      TS_EX2_IR:   tap_next = m ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   tap_next = m ? TS_SEL_DR   : TS_IDLE;
      default:     tap_next = TS_RESET;
    endcase
  endfunction

endpackage

// File: rtl/dbg_tap_ctrl.sv
module dbg_tap_ctrl
  import dbg_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e state_nxt
);

  assign state_nxt = tap_next(state, tms);

  always_ff @(posedge clk) begin
    if (rst) state <= TS_RESET;
    else     state <= state_nxt;
  end

  // R2
  tlr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TS_RESET && tms) |=> state == TS_RESET);

  // R2
  sel_ir_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TS_SEL_IR && tms) |=> state == TS_RESET);

endmodule

// File: rtl/dbg_tap_ireg.sv
module dbg_tap_ireg
  import dbg_tap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir,
  output logic [IR_W-1:0] ir_nxt,
  output logic            ir_lsb
);

  localparam logic [IR_W-1:0] CAP_PATTERN = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] ir_sr;

  always_comb begin
    case (state)
      TS_RESET:  ir_nxt = OP_BYPASS;
      TS_UPD_IR: ir_nxt = ir_sr;
      default:   ir_nxt = ir;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir    <= OP_BYPASS;
      ir_sr <= '0;
    end else begin
      ir <= ir_nxt;
      if (state == TS_CAP_IR)        ir_sr <= CAP_PATTERN;
      else if (state == TS_SHIFT_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  assign ir_lsb = ir_sr[0];

  // R2
  ir_reset_chk: assert property (@(posedge clk) disable iff (rst)
    state == TS_RESET |=> ir == OP_BYPASS);

  // R3
  ir_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir));

endmodule

// File: rtl/dbg_tap_dregs.sv
module dbg_tap_dregs
  import dbg_tap_pkg::*;
#(
  parameter int INSTR_W    = 32,
  parameter int CHAIN_W    = 5,
  parameter int CTRL_W     = 32,
  parameter int ITX_CHAIN  = 4,
  parameter int CTRL_CHAIN = 1,
  parameter int HALT_BIT   = 14,
  parameter int ABORT_BIT  = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tdi,
  input  tap_state_e         state,
  input  logic [IR_W-1:0]    ir,
  input  logic               core_halted,
  input  logic               instr_done,
  input  logic               core_abort,
  output logic               instr_valid,
  output logic [INSTR_W-1:0] instr_word,
  output logic               halt_en,
  output logic               dr_lsb
);

  localparam int ITX_W = INSTR_W + 1;
  localparam logic [CHAIN_W-1:0] ITX_ID  = CHAIN_W'(ITX_CHAIN);
  localparam logic [CHAIN_W-1:0] CTRL_ID = CHAIN_W'(CTRL_CHAIN);

  logic [CHAIN_W-1:0] chain_sel;
  logic [CHAIN_W-1:0] chsel_sr;
  logic [ITX_W-1:0]   itx_sr;
  logic [CTRL_W-1:0]  ctrl_sr;
  logic [CTRL_W-1:0]  ctrl_val;
  logic               byp_sr;
  logic               cmpl;
  logic               abort_q;
  dr_sel_e            dsel;
  logic               chain_op;
  logic               issue_ok;
  logic               is_cap, is_shift, is_upd, issue;

  assign chain_op = (ir == OP_WRITE) || (ir == OP_READ);
  assign issue_ok = (ir == OP_ITXDIR) || (ir == OP_WRITE && chain_sel == ITX_ID);

  always_comb begin
    if (ir == OP_CHSEL)                          dsel = DR_CHSEL;
    else if (ir == OP_ITXDIR)                    dsel = DR_ITX;
    else if (chain_op && chain_sel == ITX_ID)    dsel = DR_ITX;
    else if (chain_op && chain_sel == CTRL_ID)   dsel = DR_CTRL;
    else                                         dsel = DR_BYPASS;
  end

  assign is_cap   = (state == TS_CAP_DR);
  assign is_shift = (state == TS_SHIFT_DR);
  assign is_upd   = (state == TS_UPD_DR);
  assign issue    = is_upd && (dsel == DR_ITX) && issue_ok && core_halted;

  // status/control image: only three bits carry state, the rest read zero
  for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrl
    if (b == 0) begin : g_halted
      assign ctrl_val[b] = core_halted;
    end else if (b == HALT_BIT) begin : g_halt
      assign ctrl_val[b] = halt_en;
    end else if (b == ABORT_BIT) begin : g_abort
      assign ctrl_val[b] = abort_q;
    end else begin : g_zero
      assign ctrl_val[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_sel   <= '0;
      chsel_sr    <= '0;
      itx_sr      <= '0;
      ctrl_sr     <= '0;
      byp_sr      <= 1'b0;
      cmpl        <= 1'b1;
      abort_q     <= 1'b0;
      halt_en     <= 1'b0;
      instr_valid <= 1'b0;
      instr_word  <= '0;
    end else begin
      instr_valid <= issue;
      if (issue)           instr_word <= itx_sr[ITX_W-1:1];
      if (issue)           cmpl <= 1'b0;
      else if (instr_done) cmpl <= 1'b1;
      if (core_abort)      abort_q <= 1'b1;

      case (dsel)
        DR_CHSEL: begin
          if (is_cap)        chsel_sr  <= chain_sel;
          else if (is_shift) chsel_sr  <= {tdi, chsel_sr[CHAIN_W-1:1]};
          else if (is_upd)   chain_sel <= chsel_sr;
        end
        DR_ITX: begin
          if (is_cap)        itx_sr <= {instr_word, cmpl};
          else if (is_shift) itx_sr <= {tdi, itx_sr[ITX_W-1:1]};
        end
        DR_CTRL: begin
          if (is_cap)        ctrl_sr <= ctrl_val;
          else if (is_shift) ctrl_sr <= {tdi, ctrl_sr[CTRL_W-1:1]};
          else if (is_upd && ir == OP_WRITE) halt_en <= ctrl_sr[HALT_BIT];
        end
        default: begin
          if (is_cap)        byp_sr <= 1'b0;
          else if (is_shift) byp_sr <= tdi;
        end
      endcase
    end
  end

  always_comb begin
    case (dsel)
      DR_CHSEL: dr_lsb = chsel_sr[0];
      DR_ITX:   dr_lsb = itx_sr[0];
      DR_CTRL:  dr_lsb = ctrl_sr[0];
      default:  dr_lsb = byp_sr;
    endcase
  end

  // R6
  issue_gate_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid |-> ($past(core_halted) && $past(state) == TS_UPD_DR));

  // R6
  issue_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> !instr_valid);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid |-> !cmpl);

  // R10
  halt_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(halt_en) && !$past(rst)) |->
      ($past(state) == TS_UPD_DR && $past(ir) == OP_WRITE));

  // R10
  abort_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> abort_q);

endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
  import dbg_tap_pkg::*;
#(
  parameter int INSTR_W    = 32,
  parameter int CHAIN_W    = 5,
  parameter int CTRL_W     = 32,
  parameter int ITX_CHAIN  = 4,
  parameter int CTRL_CHAIN = 1,
  parameter int HALT_BIT   = 14,
  parameter int ABORT_BIT  = 19
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  input  logic               core_halted,
  input  logic               instr_done,
  input  logic               core_abort,
  output logic               instr_valid,
  output logic [INSTR_W-1:0] instr_word,
  output logic               restart_req,
  output logic               halt_en
);

  tap_state_e      state, state_nxt;
  logic [IR_W-1:0] ir, ir_nxt;
  logic            ir_lsb, dr_lsb;

  dbg_tap_ctrl u_ctrl (
    .clk(tck), .rst(rst), .tms(tms), .state(state), .state_nxt(state_nxt)
  );

  dbg_tap_ireg u_ireg (
    .clk(tck), .rst(rst), .tdi(tdi), .state(state),
    .ir(ir), .ir_nxt(ir_nxt), .ir_lsb(ir_lsb)
  );

  dbg_tap_dregs #(
    .INSTR_W(INSTR_W), .CHAIN_W(CHAIN_W), .CTRL_W(CTRL_W),
    .ITX_CHAIN(ITX_CHAIN), .CTRL_CHAIN(CTRL_CHAIN),
    .HALT_BIT(HALT_BIT), .ABORT_BIT(ABORT_BIT)
  ) u_dregs (
    .clk(tck), .rst(rst), .tdi(tdi), .state(state), .ir(ir),
    .core_halted(core_halted), .instr_done(instr_done), .core_abort(core_abort),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .halt_en(halt_en), .dr_lsb(dr_lsb)
  );

  always_ff @(posedge tck) begin
    if (rst) restart_req <= 1'b0;
    else     restart_req <= (state_nxt == TS_IDLE) && (state != TS_IDLE) &&
                            (ir_nxt == OP_RESTART);
  end

  always_comb begin
    if (state == TS_SHIFT_IR)      tdo = ir_lsb;
    else if (state == TS_SHIFT_DR) tdo = dr_lsb;
    else                           tdo = 1'b0;
  end

  // R9
  restart_pulse_chk: assert property (@(posedge tck) disable iff (rst)
    restart_req |=> !restart_req);

  // R9
  restart_idle_chk: assert property (@(posedge tck) disable iff (rst)
    restart_req |-> (state == TS_IDLE && ir == OP_RESTART));

endmodule

// File: tb/dbg_tap_tb.sv
`timescale 1ns/100ps
module dbg_tap_tb;

  logic tck = 1'b0;
  logic rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic core_halted = 1'b0, instr_done = 1'b0, core_abort = 1'b0;
  logic tdo, instr_valid, restart_req, halt_en;
  logic [31:0] instr_word;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 tck = ~tck;

  dbg_tap u_dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .core_halted(core_halted), .instr_done(instr_done), .core_abort(core_abort),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .restart_req(restart_req), .halt_en(halt_en)
  );

  // ---------------- reference model ----------------
  localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4, S_EX1DR = 5,
                 S_PADR = 6, S_EX2DR = 7, S_UPDR = 8, S_SELIR = 9, S_CAPIR = 10,
                 S_SHIR = 11, S_EX1IR = 12, S_PAIR = 13, S_EX2IR = 14, S_UPIR = 15;

  function automatic int nxt(input int s, input logic m);
    case (s)
      S_TLR:   return m ? S_TLR : S_RTI;
      S_RTI:   return m ? S_SELDR : S_RTI;
      S_SELDR: return m ? S_SELIR : S_CAPDR;
      S_CAPDR, S_SHDR: return m ? S_EX1DR : S_SHDR;
      S_EX1DR: return m ? S_UPDR : S_PADR;
      S_PADR:  return m ? S_EX2DR : S_PADR;
      S_EX2DR: return m ? S_UPDR : S_SHDR;
      S_SELIR: return m ? S_TLR : S_CAPIR;
      S_CAPIR, S_SHIR: return m ? S_EX1IR : S_SHIR;
      S_EX1IR: return m ? S_UPIR : S_PAIR;
      S_PAIR:  return m ? S_EX2IR : S_PAIR;
      S_EX2IR: return m ? S_UPIR : S_SHIR;
      default: return m ? S_SELDR : S_RTI;
    endcase
  endfunction

  // 0 bypass, 1 chain-number, 2 instruction chain, 3 status/control
  function automatic int sel(input logic [3:0] ir, input logic [4:0] ch);
    if (ir == 4'h2) return 1;
    if (ir == 4'hD) return 2;
    if ((ir == 4'h0 || ir == 4'hC) && ch == 5'd4) return 2;
    if ((ir == 4'h0 || ir == 4'hC) && ch == 5'd1) return 3;
    return 0;
  endfunction

  int          m_st;
  logic [3:0]  m_ir, m_irsr;
  logic [4:0]  m_chain, m_scan;
  logic [32:0] m_itr;
  logic [31:0] m_dscr, m_word;
  logic        m_byp, m_cmpl, m_halt, m_abort, m_valid, m_rstq;
  bit          m_started = 0;

  always @(posedge tck) begin
    int ns, ds;
    logic [3:0] new_ir;
    logic [31:0] dval;
    logic ok, iss;
    if (rst) begin
      m_st = S_TLR; m_ir = 4'hF; m_irsr = 0; m_chain = 0; m_scan = 0; m_itr = 0;
      m_dscr = 0; m_byp = 0; m_cmpl = 1; m_halt = 0; m_abort = 0; m_valid = 0;
      m_word = 0; m_rstq = 0;
    end else begin
      ns = nxt(m_st, tms);
      ds = sel(m_ir, m_chain);
      ok = (m_ir == 4'hD) || (m_ir == 4'h0 && m_chain == 5'd4);
      new_ir = (m_st == S_TLR) ? 4'hF : (m_st == S_UPIR) ? m_irsr : m_ir;
      if (m_st == S_CAPIR) m_irsr = 4'b0001;
      else if (m_st == S_SHIR) m_irsr = {tdi, m_irsr[3:1]};
      m_rstq = (ns == S_RTI) && (m_st != S_RTI) && (new_ir == 4'h4);
      iss = (m_st == S_UPDR) && (ds == 2) && ok && core_halted;
      dval = 0; dval[0] = core_halted; dval[14] = m_halt; dval[19] = m_abort;
      case (ds)
        1: if (m_st == S_CAPDR) m_scan = m_chain;
           else if (m_st == S_SHDR) m_scan = {tdi, m_scan[4:1]};
           else if (m_st == S_UPDR) m_chain = m_scan;
        2: if (m_st == S_CAPDR) m_itr = {m_word, m_cmpl};
           else if (m_st == S_SHDR) m_itr = {tdi, m_itr[32:1]};
        3: if (m_st == S_CAPDR) m_dscr = dval;
           else if (m_st == S_SHDR) m_dscr = {tdi, m_dscr[31:1]};
           else if (m_st == S_UPDR && m_ir == 4'h0) m_halt = m_dscr[14];
        default: if (m_st == S_CAPDR) m_byp = 0; else if (m_st == S_SHDR) m_byp = tdi;
      endcase
      m_valid = iss;
      if (iss) m_word = m_itr[32:1];
      if (iss) m_cmpl = 0; else if (instr_done) m_cmpl = 1;
      if (core_abort) m_abort = 1;
      m_ir = new_ir;
      m_st = ns;
    end
    m_started = 1;
  end

  function automatic logic exp_tdo();
    if (m_st == S_SHIR) return m_irsr[0];
    if (m_st == S_SHDR) case (sel(m_ir, m_chain))
      1: return m_scan[0];
      2: return m_itr[0];
      3: return m_dscr[0];
      default: return m_byp;
    endcase
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge tck) if (m_started && !finished) begin
    chk(tdo === exp_tdo(), "R11 tdo", 64'(tdo), 64'(exp_tdo()));
    chk(instr_valid === m_valid, "R6 instr_valid", 64'(instr_valid), 64'(m_valid));
    chk(instr_word === m_word, "R6 instr_word", 64'(instr_word), 64'(m_word));
    chk(restart_req === m_rstq, "R9 restart_req", 64'(restart_req), 64'(m_rstq));
    chk(halt_en === m_halt, "R10 halt_en", 64'(halt_en), 64'(m_halt));
  end

  // pulse monitor
  int n_issue = 0, n_restart = 0;
  always @(negedge tck) if (!rst) begin
    if (instr_valid) n_issue++;
    if (restart_req) n_restart++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input logic t, input logic d, output logic o);
    @(negedge tck); o = tdo; #1; tms = t; tdi = d;
  endtask

  task automatic idle(input int n);
    logic x;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, x);
  endtask

  task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
    logic x, o;
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o); cap[i] = o;
    end
    step(1, 0, x); step(0, 0, x); idle(2);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, input logic dn,
                          output logic [63:0] dout);
    logic x, o;
    dout = '0;
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o); dout[i] = o;
    end
    step(1, 0, x);
    @(negedge tck); #1; tms = 0; instr_done = dn;
    @(negedge tck); #1; instr_done = 0;
    idle(1);
  endtask

  task automatic pulse_done();
    @(negedge tck); #1; instr_done = 1;
    @(negedge tck); #1; instr_done = 0;
  endtask

  task automatic pulse_abort();
    @(negedge tck); #1; core_abort = 1;
    @(negedge tck); #1; core_abort = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- scenario ----------------
  initial begin
    logic [3:0] c;
    logic [63:0] d;
    logic x;
    int k;
    repeat (3) @(negedge tck);
    #1; rst = 0;
    @(negedge tck);
    chk(tdo == 0 && instr_valid == 0 && restart_req == 0 && halt_en == 0 && instr_word == 0,
        "R1 reset outputs", {instr_word, 1'b0, tdo, instr_valid, restart_req, halt_en}, 0);
    #1; tms = 0;
    idle(2);

    // IR capture and chain select
    shift_ir(4'h2, c);
    chk(c == 4'b0001, "R3 ir capture", c, 4'b0001);
    shift_dr(5, 64'd1, 0, d);
    chk(d[4:0] == 0, "R1 chain after reset", d[4:0], 0);
    shift_dr(5, 64'd4, 0, d);
    chk(d[4:0] == 1, "R4 chain readback", d[4:0], 1);
    shift_dr(5, 64'd4, 0, d);
    chk(d[4:0] == 4, "R4 chain readback 4", d[4:0], 4);

    // issue through write-side opcode on chain 4
    core_halted = 1;
    shift_ir(4'h0, c);
    shift_dr(33, {31'b0, 32'hDEADBEEF, 1'b1}, 0, d);
    chk(d[0] == 1, "R7 flag after reset", d[0], 1);
    chk(d[32:1] == 0, "R5 capture old word", d[32:1], 0);
    chk(n_issue == 1 && instr_word == 32'hDEADBEEF, "R6 issue", {n_issue, instr_word},
        {32'd1, 32'hDEADBEEF});
    shift_dr(33, {31'b0, 32'h12345678, 1'b0}, 0, d);
    chk(d[0] == 0, "R7 flag cleared by issue", d[0], 0);
    chk(d[32:1] == 32'hDEADBEEF, "R5 capture last word", d[32:1], 32'hDEADBEEF);
    chk(n_issue == 2, "R6 second issue", n_issue, 2);

    // done sets flag, read-side opcode does not issue
    pulse_done();
    shift_ir(4'hC, c);
    shift_dr(33, {31'b0, 32'hCAFEF00D, 1'b1}, 0, d);
    chk(d[0] == 1, "R7 flag set by done", d[0], 1);
    chk(n_issue == 2 && instr_word == 32'h12345678, "R6 no issue under read opcode",
        n_issue, 2);

    // read-only flag position
    shift_ir(4'h0, c);
    shift_dr(33, {31'b0, 32'hAAAA5555, 1'b0}, 0, d);
    shift_ir(4'hC, c);
    shift_dr(33, {31'b0, 32'h0F0F0F0F, 1'b1}, 0, d);
    chk(d[0] == 0, "R8 flag after issue", d[0], 0);
    shift_dr(33, {31'b0, 32'h0, 1'b1}, 0, d);
    chk(d[0] == 0, "R8 shifted bit 0 ignored", d[0], 0);
    chk(d[32:1] == 32'hAAAA5555 && n_issue == 3, "R8 word untouched", d[32:1], 32'hAAAA5555);

    // core running: no issue
    core_halted = 0;
    shift_ir(4'h0, c);
    shift_dr(33, {31'b0, 32'h11112222, 1'b0}, 0, d);
    chk(n_issue == 3, "R6 no issue when running", n_issue, 3);
    core_halted = 1;

    // issue and done in the same edge
    shift_dr(33, {31'b0, 32'h33334444, 1'b0}, 1, d);
    chk(n_issue == 4, "R6 issue with done", n_issue, 4);
    shift_ir(4'hC, c);
    shift_dr(33, 64'd0, 0, d);
    chk(d[0] == 0, "R7 issue wins over done", d[0], 0);

    // direct select opcode with another chain selected
    shift_ir(4'h2, c);
    shift_dr(5, 64'd1, 0, d);
    shift_ir(4'hD, c);
    shift_dr(33, {31'b0, 32'h5A5A0F0F, 1'b0}, 0, d);
    chk(n_issue == 5 && instr_word == 32'h5A5A0F0F, "R5 direct select issues",
        {n_issue, instr_word}, {32'd5, 32'h5A5A0F0F});

    // status/control chain
    shift_ir(4'h0, c);
    shift_dr(32, 64'h4000, 0, d);
    chk(d[31:0] == 32'h1, "R10 status read", d[31:0], 32'h1);
    chk(halt_en == 1, "R10 halt enable write", halt_en, 1);
    pulse_abort();
    shift_ir(4'hC, c);
    shift_dr(32, 64'd0, 0, d);
    chk(d[31:0] == 32'h84001, "R10 abort and enable read", d[31:0], 32'h84001);
    chk(halt_en == 1, "R10 read opcode no write", halt_en, 1);
    shift_ir(4'h0, c);
    shift_dr(32, 64'd0, 0, d);
    chk(halt_en == 0, "R10 halt enable cleared", halt_en, 0);
    shift_dr(32, 64'd0, 0, d);
    chk(d[31:0] == 32'h80001, "R10 abort sticky", d[31:0], 32'h80001);

    // bypass on an unknown opcode
    shift_ir(4'h7, c);
    shift_dr(4, 64'hB, 0, d);
    chk(d[3:0] == 4'h6, "R3 bypass delay", d[3:0], 4'h6);

    // restart
    k = n_restart;
    shift_ir(4'h4, c);
    chk(n_restart == k + 1, "R9 restart on entry", n_restart, k + 1);
    idle(4);
    chk(n_restart == k + 1, "R9 no repeat in idle", n_restart, k + 1);
    shift_dr(1, 64'd0, 0, d);
    chk(n_restart == k + 2, "R9 restart from update-dr", n_restart, k + 2);
    shift_ir(4'hF, c);
    chk(n_restart == k + 2, "R9 no restart under bypass", n_restart, k + 2);

    // five TMS-high edges reset the controller and the IR
    shift_ir(4'h2, c);
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 5; i++) step(1, 0, x);
    step(0, 0, x);
    idle(2);
    shift_dr(4, 64'hB, 0, d);
    chk(d[3:0] == 4'h6, "R2 bypass after tms reset", d[3:0], 4'h6);

    // synchronous reset mid-run
    @(negedge tck); #1; rst = 1; tms = 1;
    @(negedge tck); #1; rst = 0; tms = 0;
    idle(2);
    chk(halt_en == 0 && instr_word == 0, "R1 reset mid-run", {halt_en, instr_word}, 0);
    shift_ir(4'h2, c);
    shift_dr(5, 64'd0, 0, d);
    chk(d[4:0] == 0, "R1 chain reset", d[4:0], 0);

    idle(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule